// File: doc/BRIEF.md
# Programmable 32-Source Interrupt Controller

This block gathers up to 32 interrupt request lines from peripherals and presents them to a processor as two level outputs: one critical and one non-critical. Software sets up each source through a small register file on a word-addressed control bus. Per source, it chooses edge or level sensing, the polarity, whether the source is enabled, and which output it drives. Raw events are held in a sticky status register, whether or not the source is enabled. Software clears status bits by writing ones to them.

Each input passes through a two-flop synchronizer before detection, so the lines may be asynchronous to the controller clock. Each output is a plain registered level. It can drive a processor pin or one input of a second controller of the same kind.

Top module: `irq_ctrl32`

## Requirements
- R1: Registers are word offsets on the bus: status 0x0, enable 0x2, class 0x3, polarity 0x4, trigger 0x5, masked status 0x6. Any other offset reads 0 and ignores writes. Read data appears on the clock edge after the address is presented.
- R2: Source n is held in register bit 31-n of every per-source register, so source 0 is the most significant bit.
- R3: Writing 1 to a status bit clears it. Writing 0 leaves it unchanged.
- R4: With trigger bit 1 the source is edge-sensed: polarity 1 catches a rising edge and polarity 0 a falling edge. An input change sampled on edge k sets the status bit on edge k+2.
- R5: With trigger bit 0 the source is level-sensed: polarity 1 is active-high and polarity 0 is active-low. While the synchronized input is active, the status bit is set again every cycle, so a clear has no lasting effect. This holds even when the source is disabled.
- R6: Status bits are set whatever the enable bits hold. Enable gates only the masked status and the outputs.
- R7: Masked status reads status AND enable. Writes to it are ignored.
- R8: The critical output is the registered OR of masked status AND class. The non-critical output is the registered OR of masked status AND NOT class. Each follows its inputs one cycle later.
- R9: When a detection and a write-one-to-clear hit the same status bit in the same cycle, the bit ends up set.
- R10: A synchronous active-high reset clears all registers, the synchronizers, the read data and both outputs. With all-zero configuration, every source is level-sensed active-low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous reset, active high |
| irq_src | input | 32 | Request lines; irq_src[n] is source n |
| bus_addr | input | 4 | Word offset of the register accessed |
| bus_wr | input | 1 | Write strobe for the current cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data for the previous cycle's address |
| irq_crit | output | 1 | Critical interrupt level |
| irq_noncrit | output | 1 | Non-critical interrupt level |

## Verification
An input change sampled on clock edge k reaches the status register on edge k+2 and the outputs on edge k+3. A register write takes effect on the edge that samples it, and its effect on the outputs appears one edge later. Read data always shows the register contents from before the edge that samples the address. The bench keeps a behavioural model that carries the same latencies: a queue of sampled input words stands in for the synchronizer. Between edges, on the falling clock, the bench compares read data and both outputs against the model. A detection and a clear that meet on the same edge are produced on purpose by lining up the clear write with edge k+2 of an input pulse.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  // Register word offsets; software decodes these, so they are fixed.
  localparam int unsigned OFS_PEND   = 0;  // sticky event status, write-one-to-clear
  localparam int unsigned OFS_ALLOW  = 2;  // per-source enable
  localparam int unsigned OFS_URGENT = 3;  // 1 = drive the critical output
  localparam int unsigned OFS_POL    = 4;  // 1 = rising / active-high
  localparam int unsigned OFS_KIND   = 5;  // 1 = edge, 0 = level
  localparam int unsigned OFS_ACTIVE = 6;  // read-only: pending AND enable
endpackage

// File: rtl/irqc_sync.sv
// Multi-stage synchronizer plus one history stage for edge detection.
module irqc_sync #(
  parameter int unsigned W      = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] cur,
  output logic [W-1:0] last
);
  localparam int unsigned DEPTH = STAGES + 1;

  logic [W-1:0] pipe [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) pipe[i] <= '0;
    end else begin
      pipe[0] <= din;
      for (int i = 1; i < DEPTH; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign cur  = pipe[STAGES-1];
  assign last = pipe[STAGES];
endmodule

// File: rtl/irqc_detect.sv
// Per-source sensing: edge or level, either polarity.
module irqc_detect #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] cur,
  input  logic [W-1:0] last,
  input  logic [W-1:0] pol,
  input  logic [W-1:0] kind,
  output logic [W-1:0] hit
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic rise, fall, edge_hit, lvl_hit;
    assign rise     = cur[b] & ~last[b];
    assign fall     = ~cur[b] & last[b];
    assign edge_hit = pol[b] ? rise : fall;
    assign lvl_hit  = ~(cur[b] ^ pol[b]);
    assign hit[b]   = kind[b] ? edge_hit : lvl_hit;
  end
endmodule

// File: rtl/irqc_regs.sv
// Register file: configuration, sticky status and registered read mux.
module irqc_regs
  import irqc_pkg::*;
#(
  parameter int unsigned W  = 32,
  parameter int unsigned AW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] addr,
  input  logic          wr,
  input  logic [W-1:0]  wdata,
  input  logic [W-1:0]  hit,
  output logic [W-1:0]  rdata,
  output logic [W-1:0]  pend,
  output logic [W-1:0]  allow,
  output logic [W-1:0]  urgent,
  output logic [W-1:0]  pol,
  output logic [W-1:0]  kind
);
  logic          sel_pend, sel_allow, sel_urgent, sel_pol, sel_kind, sel_active;
  logic [W-1:0]  wipe;
  logic [W-1:0]  rd_mux;

  assign sel_pend   = (addr == AW'(OFS_PEND));
  assign sel_allow  = (addr == AW'(OFS_ALLOW));
  assign sel_urgent = (addr == AW'(OFS_URGENT));
  assign sel_pol    = (addr == AW'(OFS_POL));
  assign sel_kind   = (addr == AW'(OFS_KIND));
  assign sel_active = (addr == AW'(OFS_ACTIVE));

  assign wipe = (wr && sel_pend) ? wdata : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend   <= '0;
      allow  <= '0;
      urgent <= '0;
      pol    <= '0;
      kind   <= '0;
    end else begin
      // a fresh detection outranks a clear of the same bit
      pend <= (pend & ~wipe) | hit;
      if (wr && sel_allow)  allow  <= wdata;
      if (wr && sel_urgent) urgent <= wdata;
      if (wr && sel_pol)    pol    <= wdata;
      if (wr && sel_kind)   kind   <= wdata;
    end
  end

  always_comb begin
    rd_mux = '0;
    if (sel_pend)   rd_mux = pend;
    if (sel_allow)  rd_mux = allow;
    if (sel_urgent) rd_mux = urgent;
    if (sel_pol)    rd_mux = pol;
    if (sel_kind)   rd_mux = kind;
    if (sel_active) rd_mux = pend & allow;
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_mux;
  end
endmodule

// File: rtl/irqc_route.sv
// Splits masked status into the two registered output levels.
module irqc_route #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] pend,
  input  logic [W-1:0] allow,
  input  logic [W-1:0] urgent,
  output logic         crit,
  output logic         noncrit
);
  logic [W-1:0] live;

  assign live = pend & allow;

  always_ff @(posedge clk) begin
    if (rst) begin
      crit    <= 1'b0;
      noncrit <= 1'b0;
    end else begin
      crit    <= |(live & urgent);
      noncrit <= |(live & ~urgent);
    end
  end
endmodule

// File: rtl/irq_ctrl32.sv
module irq_ctrl32 #(
  parameter int unsigned N_SRC       = 32,
  parameter int unsigned ADDR_W      = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_SRC-1:0]  irq_src,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [N_SRC-1:0]  bus_wdata,
  output logic [N_SRC-1:0]  bus_rdata,
  output logic              irq_crit,
  output logic              irq_noncrit
);
  localparam int unsigned TOP = N_SRC - 1;

  logic [N_SRC-1:0] src_bits;   // register bit order: source n at bit TOP-n
  logic [N_SRC-1:0] cur_s, last_s, set_v;
  logic [N_SRC-1:0] pend_q, allow_q, urgent_q, pol_q, kind_q;

  for (genvar n = 0; n < N_SRC; n++) begin : g_order
    assign src_bits[TOP-n] = irq_src[n];
  end

  irqc_sync #(.W(N_SRC), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  (src_bits),
    .cur  (cur_s),
    .last (last_s)
  );

  irqc_detect #(.W(N_SRC)) u_detect (
    .cur  (cur_s),
    .last (last_s),
    .pol  (pol_q),
    .kind (kind_q),
    .hit  (set_v)
  );

  irqc_regs #(.W(N_SRC), .AW(ADDR_W)) u_regs (
    .clk    (clk),
    .rst    (rst),
    .addr   (bus_addr),
    .wr     (bus_wr),
    .wdata  (bus_wdata),
    .hit    (set_v),
    .rdata  (bus_rdata),
    .pend   (pend_q),
    .allow  (allow_q),
    .urgent (urgent_q),
    .pol    (pol_q),
    .kind   (kind_q)
  );

  irqc_route #(.W(N_SRC)) u_route (
    .clk     (clk),
    .rst     (rst),
    .pend    (pend_q),
    .allow   (allow_q),
    .urgent  (urgent_q),
    .crit    (irq_crit),
    .noncrit (irq_noncrit)
  );
endmodule

// File: rtl/irqc_checker.sv
module irqc_checker
  import irqc_pkg::*;
#(
  parameter int unsigned W  = 32,
  parameter int unsigned AW = 4
) (
  input logic          clk,
  input logic          rst,
  input logic [AW-1:0] addr,
  input logic          wr,
  input logic [W-1:0]  wdata,
  input logic [W-1:0]  rdata,
  input logic          crit,
  input logic          noncrit,
  input logic [W-1:0]  pend,
  input logic [W-1:0]  allow,
  input logic [W-1:0]  urgent,
  input logic [W-1:0]  pol,
  input logic [W-1:0]  kind,
  input logic [W-1:0]  cur,
  input logic [W-1:0]  hit
);
  logic         unused_a;
  logic [W-1:0] lvl_act;

  assign unused_a = !(addr == AW'(OFS_PEND)   || addr == AW'(OFS_ALLOW) ||
                      addr == AW'(OFS_URGENT) || addr == AW'(OFS_POL)   ||
                      addr == AW'(OFS_KIND)   || addr == AW'(OFS_ACTIVE));
  assign lvl_act  = ~kind & ~(cur ^ pol);

  a_r10_reset_quiet: assert property (@(posedge clk)
    rst |=> (rdata == '0 && !crit && !noncrit));

  a_r1_unused_zero: assert property (@(posedge clk) disable iff (rst)
    unused_a |=> (rdata == '0));

  a_r7_active_read: assert property (@(posedge clk) disable iff (rst)
    (addr == AW'(OFS_ACTIVE)) |=> (rdata == $past(pend & allow)));

  a_r3_clear_works: assert property (@(posedge clk) disable iff (rst)
    (wr && addr == AW'(OFS_PEND)) |=> ((pend & $past(wdata & ~hit)) == '0));

  a_r9_set_lands: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ((pend & $past(hit)) == $past(hit)));

  a_r5_level_sticks: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ((pend & $past(lvl_act)) == $past(lvl_act)));

  a_r8_crit_level: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (crit == $past(|(pend & allow & urgent))));

  a_r8_noncrit_level: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (noncrit == $past(|(pend & allow & ~urgent))));
endmodule

bind irq_ctrl32 irqc_checker #(.W(N_SRC), .AW(ADDR_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .addr    (bus_addr),
  .wr      (bus_wr),
  .wdata   (bus_wdata),
  .rdata   (bus_rdata),
  .crit    (irq_crit),
  .noncrit (irq_noncrit),
  .pend    (pend_q),
  .allow   (allow_q),
  .urgent  (urgent_q),
  .pol     (pol_q),
  .kind    (kind_q),
  .cur     (cur_s),
  .hit     (set_v)
);

// File: tb/irq_ctrl32_bench.sv
`timescale 1ns/1ps
module irq_ctrl32_bench;
  localparam int N = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [N-1:0]  irq_src = '0;
  logic [3:0]    bus_addr = '0;
  logic          bus_wr = 1'b0;
  logic [N-1:0]  bus_wdata = '0;
  logic [N-1:0]  bus_rdata;
  logic          irq_crit, irq_noncrit;

  int    n_cmp = 0;
  int    n_bad = 0;
  int    cyc   = 0;
  bit    armed = 1'b0;
  bit    done  = 1'b0;
  string phase = "R10 reset";

  always #4 clk = ~clk;  // 125 MHz

  irq_ctrl32 u_irq_ctrl32 (
    .clk         (clk),
    .rst         (rst),
    .irq_src     (irq_src),
    .bus_addr    (bus_addr),
    .bus_wr      (bus_wr),
    .bus_wdata   (bus_wdata),
    .bus_rdata   (bus_rdata),
    .irq_crit    (irq_crit),
    .irq_noncrit (irq_noncrit)
  );

  // ---------------- behavioural reference ----------------
  bit [31:0] m_st, m_en, m_cl, m_pl, m_tg, m_rd;
  bit        m_cr, m_nc;
  bit [31:0] hist [$];   // sampled input words, newest first

  always @(posedge clk) begin
    bit [31:0] s2, pv, hits, clr, raw, act;
    if (rst) begin
      m_st = 0; m_en = 0; m_cl = 0; m_pl = 0; m_tg = 0; m_rd = 0;
      m_cr = 0; m_nc = 0;
      hist = '{32'd0, 32'd0, 32'd0};
      armed = 1'b1;
    end else begin
      s2 = hist[1];
      pv = hist[2];
      for (int b = 0; b < 32; b++) begin
        if (m_tg[b]) hits[b] = m_pl[b] ? (s2[b] && !pv[b]) : (!s2[b] && pv[b]);
        else         hits[b] = (s2[b] == m_pl[b]);
      end
      act = m_st & m_en;
      case (int'(bus_addr))
        0: m_rd = m_st;
        2: m_rd = m_en;
        3: m_rd = m_cl;
        4: m_rd = m_pl;
        5: m_rd = m_tg;
        6: m_rd = act;
        default: m_rd = 0;
      endcase
      m_cr = ((act & m_cl) != 0);
      m_nc = ((act & ~m_cl) != 0);
      clr = (bus_wr && bus_addr == 4'd0) ? bus_wdata : 32'd0;
      m_st = (m_st & ~clr) | hits;
      if (bus_wr) begin
        case (int'(bus_addr))
          2: m_en = bus_wdata;
          3: m_cl = bus_wdata;
          4: m_pl = bus_wdata;
          5: m_tg = bus_wdata;
          default: ;
        endcase
      end
      for (int n = 0; n < 32; n++) raw[31-n] = irq_src[n];
      hist.push_front(raw);
      void'(hist.pop_back());
    end
  end

  // ---------------- comparison away from the rising edge ----------------
  always @(negedge clk) begin
    if (armed && !done) begin
      n_cmp++;
      if (bus_rdata !== m_rd) begin
        n_bad++;
        $display("FAIL [%s] R1 R7 rdata addr-prev actual %h expected %h", phase, bus_rdata, m_rd);
      end
      n_cmp++;
      if (irq_crit !== m_cr) begin
        n_bad++;
        $display("FAIL [%s] R8 irq_crit actual %0b expected %0b", phase, irq_crit, m_cr);
      end
      n_cmp++;
      if (irq_noncrit !== m_nc) begin
        n_bad++;
        $display("FAIL [%s] R8 irq_noncrit actual %0b expected %0b", phase, irq_noncrit, m_nc);
      end
    end
  end

  // ---------------- watchdog ----------------
  always @(posedge clk) begin
    cyc++;
    if (cyc == 50000 && !done) begin
      done = 1'b1;
      n_bad++;
      $display("FAIL [%s] watchdog actual %0d cycles expected completion", phase, cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic put(input int a, input bit [31:0] d);
    @(negedge clk);
    bus_addr = 4'(a); bus_wr = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic look(input int a);
    @(negedge clk);
    bus_addr = 4'(a);
    tick(2);
  endtask

  function automatic bit [31:0] srcbit(input int n);
    return 32'h1 << (31 - n);   // R2: source n at bit 31-n
  endfunction

  initial begin
    tick(4);
    rst = 1'b0;

    // R10 R5: default configuration is level, active-low; idle-low inputs set status
    phase = "R10 R5 default level-low";
    look(0);
    tick(4);

    // R1: readback of each configuration register and unused offsets
    phase = "R1 readback";
    put(2, 32'h0);
    put(3, 32'hA5A5_0F0F);
    put(4, 32'hFFFF_FFFF);
    put(5, 32'hFFFF_FFFF);
    look(2); look(3); look(4); look(5);
    put(1, 32'hFFFF_FFFF); look(1);
    put(7, 32'h1234_5678); look(7);
    put(8, 32'hFFFF_FFFF); look(8);
    put(15, 32'hDEAD_BEEF); look(15);

    // R3: zeros leave status, ones clear it
    phase = "R3 clear";
    put(0, 32'h0); look(0);
    put(0, 32'hFFFF_FFFF); look(0);

    // R7: masked status ignores writes
    phase = "R7 masked read-only";
    put(6, 32'hFFFF_FFFF); look(6); look(0);

    // R2 R4: rising edge on source 3 lands in bit 28
    phase = "R2 R4 rising edge";
    irq_src[3] = 1'b1;
    tick(5); look(0);
    phase = "R8 noncritical route";
    put(2, srcbit(3)); tick(3);
    phase = "R8 critical route";
    put(3, srcbit(3)); tick(3); look(6);
    put(0, srcbit(3)); tick(3);

    // R4: falling edge on source 5
    phase = "R4 falling edge";
    put(4, ~srcbit(5));
    irq_src[5] = 1'b1; tick(5);
    put(0, 32'hFFFF_FFFF); look(0);
    irq_src[5] = 1'b0; tick(5); look(0);

    // R5 R6: level-high source 7, disabled, clear does not stick
    phase = "R5 R6 level held while disabled";
    put(2, 32'h0);
    put(4, 32'hFFFF_FFFF);
    put(5, ~srcbit(7));
    irq_src[7] = 1'b1; tick(5);
    put(0, srcbit(7)); tick(2); look(0); look(6);
    irq_src[7] = 1'b0; tick(4);
    put(0, srcbit(7)); look(0);

    // R9: edge detection coincides with a clear of the same bit
    phase = "R9 set beats clear";
    put(0, 32'hFFFF_FFFF);
    @(negedge clk); irq_src[9] = 1'b1;
    @(negedge clk);
    @(negedge clk); bus_addr = 4'd0; bus_wr = 1'b1; bus_wdata = srcbit(9);
    @(negedge clk); bus_wr = 1'b0;
    tick(2); look(0);

    // Mixed traffic across all requirements R1 R2 R3 R4 R5 R6 R7 R8 R9
    phase = "R1 R2 R3 R4 R5 R6 R7 R8 R9 mixed";
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      if ($urandom_range(0, 3) == 0) irq_src = $urandom();
      bus_addr  = 4'($urandom_range(0, 15));
      bus_wr    = ($urandom_range(0, 4) == 0);
      bus_wdata = $urandom();
    end
    @(negedge clk); bus_wr = 1'b0;
    tick(4);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule